// File: doc/BRIEF.md
# Floating-Point Sticky Status and Trap Gate

This block sits beside a single-precision floating-point unit and turns the per-operation exception indications into architectural state. Each completed operation presents four flags (invalid operation, divide by zero, overflow, underflow) together with a valid strobe. The block ORs the flags into four sticky bits of a floating-point status word. A separate write port lets software clear or set those bits. A software write and a flag update can land in the same cycle: the write settles the bits it covers first, and the incoming flags are then ORed on top.

Whenever an operation reports at least one flag, the block considers raising a hardware exception. It does so only if a static configuration bit enables floating-point traps and the processor's runtime exception-enable bit is also set. The block first loads a fixed floating-point cause code into its exception-cause output. On the following cycle it issues a one-cycle request pulse, so the cause is already in place when the trap logic sees the request. Comparison operations may only report an invalid operation; any other flag they carry is dropped before it is accumulated or used to raise an exception.

Top module: `fpu_flag_gate`

## Requirements
- R1: After reset, `fsr`, `esr_cause` and `exc_req` are all zero.
- R2: The flag input uses `op_flags[0]`=invalid, `[1]`=divide by zero, `[2]`=overflow and `[3]`=underflow. With default parameters these map to `fsr` bits 4, 3, 2 and 1, and every other `fsr` bit reads zero. A flag presented with `op_valid` high appears in `fsr` in the cycle after the clock edge that samples it.
- R3: Sticky bits are never cleared by operations; only a software write can lower them.
- R4: When `op_is_cmp` is high, only `op_flags[0]` is accumulated or counted toward a raise; bits 1 to 3 have no effect on `fsr`, `esr_cause` or `exc_req`.
- R5: With `op_valid` low, `op_flags`, `op_is_cmp`, `cfg_trap_en` and `core_exc_en` have no effect on any output.
- R6: An exception is requested for a valid operation only when at least one effective flag is set, `cfg_trap_en` is high and `core_exc_en` is high; if any of the three is missing, no request follows.
- R7: For a qualifying operation sampled at edge k, `esr_cause` holds `CAUSE_CODE` (default 6) from edge k on, and `exc_req` is high for exactly the one cycle that follows edge k+1. Each qualifying operation yields its own pulse, and `esr_cause` keeps its value otherwise.
- R8: When `sw_we` is high, each sticky bit selected by `sw_mask` (same bit order as R2) takes the value of `sw_data`, and unselected bits keep their value. The effective flags of a simultaneous valid operation are then ORed in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_is_cmp | input | 1 | The operation is a comparison |
| op_flags | input | 4 | Invalid, divide by zero, overflow, underflow (bits 0..3) |
| cfg_trap_en | input | 1 | Static enable for floating-point traps |
| core_exc_en | input | 1 | Runtime exception-enable bit of the processor status |
| sw_we | input | 1 | Software write to the sticky bits |
| sw_mask | input | 4 | Sticky bits that the write covers |
| sw_data | input | 4 | Values written to the covered bits |
| fsr | output | SR_W | Floating-point status word holding the sticky bits |
| esr_cause | output | CAUSE_W | Exception cause code |
| exc_req | output | 1 | One-cycle hardware exception request |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a software write and an operation's flags arrive together. The bench provokes this with masks that clear a bit while the same bit is being reported, and with masks that clear one bit while a different bit is reported. It judges the result by requiring that the reported flag survives and the untouched bits hold. In the second, a qualifying operation follows directly on another, so a new cause load and the previous request pulse share a cycle; back-to-back qualifying operations must give pulses on consecutive cycles with the cause already present. A behavioural model in the bench predicts all three outputs every cycle over directed and random traffic.

// File: rtl/fpu_flag_gate.sv
module fpu_flag_gate #(
  parameter int SR_W = 32,
  parameter int INV_POS = 4,
  parameter int DZ_POS = 3,
  parameter int OVF_POS = 2,
  parameter int UNF_POS = 1,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 5'd6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic               op_is_cmp,
  input  logic [3:0]         op_flags,
  input  logic               cfg_trap_en,
  input  logic               core_exc_en,
  input  logic               sw_we,
  input  logic [3:0]         sw_mask,
  input  logic [3:0]         sw_data,
  output logic [SR_W-1:0]    fsr,
  output logic [CAUSE_W-1:0] esr_cause,
  output logic               exc_req
);
  localparam int NF = 4;
  localparam int POS [NF] = '{INV_POS, DZ_POS, OVF_POS, UNF_POS};

  logic [NF-1:0] sticky, eff, base;
  logic          raise, pend;

  assign eff   = !op_valid ? '0 : (op_is_cmp ? (op_flags & 4'b0001) : op_flags);
  assign raise = (|eff) && cfg_trap_en && core_exc_en;
  assign base  = sw_we ? ((sticky & ~sw_mask) | (sw_data & sw_mask)) : sticky;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky    <= '0;
      esr_cause <= '0;
      pend      <= 1'b0;
      exc_req   <= 1'b0;
    end else begin
      sticky  <= base | eff;
      pend    <= raise;
      exc_req <= pend;
      if (raise) esr_cause <= CAUSE_CODE;
    end
  end

  always_comb begin
    fsr = '0;
    for (int i = 0; i < NF; i++) fsr[POS[i]] = sticky[i];
  end
endmodule

module fpu_flag_gate_chk #(
  parameter int SR_W = 32,
  parameter int INV_POS = 4,
  parameter int DZ_POS = 3,
  parameter int OVF_POS = 2,
  parameter int UNF_POS = 1,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_CODE = 5'd6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic               op_is_cmp,
  input logic [3:0]         op_flags,
  input logic               cfg_trap_en,
  input logic               core_exc_en,
  input logic               sw_we,
  input logic [SR_W-1:0]    fsr,
  input logic [CAUSE_W-1:0] esr_cause,
  input logic               exc_req
);
  assert_cause_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> esr_cause == CAUSE_CODE);

  assert_req_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && cfg_trap_en && core_exc_en && (op_flags[0] || (!op_is_cmp && |op_flags))) |=> ##1 exc_req);

  assert_no_req_without_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_trap_en || !core_exc_en || !op_valid) |=> ##1 !exc_req);

  assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((fsr & $past(fsr)) == $past(fsr)));

  assert_cmp_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_cmp && !sw_we && !fsr[DZ_POS] && !fsr[OVF_POS] && !fsr[UNF_POS])
      |=> (!fsr[DZ_POS] && !fsr[OVF_POS] && !fsr[UNF_POS]));

  assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !sw_we) |=> $stable(fsr));

  assert_inv_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_flags[0]) |=> fsr[INV_POS]);
endmodule

bind fpu_flag_gate fpu_flag_gate_chk #(
  .SR_W(SR_W), .INV_POS(INV_POS), .DZ_POS(DZ_POS), .OVF_POS(OVF_POS),
  .UNF_POS(UNF_POS), .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
  .op_flags(op_flags), .cfg_trap_en(cfg_trap_en), .core_exc_en(core_exc_en),
  .sw_we(sw_we), .fsr(fsr), .esr_cause(esr_cause), .exc_req(exc_req)
);

// File: tb/sim_fpu_flag_gate.sv
module sim_fpu_flag_gate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_is_cmp = 0, cfg_trap_en = 0, core_exc_en = 0, sw_we = 0;
  logic [3:0] op_flags = 0, sw_mask = 0, sw_data = 0;
  logic [31:0] fsr;
  logic [4:0] esr_cause;
  logic exc_req;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [3:0] m_st = 0;
  logic [4:0] m_esr = 0;
  bit m_pend = 0, m_req = 0;

  always #2.5 clk = ~clk;

  fpu_flag_gate u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_cmp(op_is_cmp),
    .op_flags(op_flags), .cfg_trap_en(cfg_trap_en), .core_exc_en(core_exc_en),
    .sw_we(sw_we), .sw_mask(sw_mask), .sw_data(sw_data),
    .fsr(fsr), .esr_cause(esr_cause), .exc_req(exc_req)
  );

  function automatic logic [31:0] place(input logic [3:0] s);
    logic [31:0] w = '0;
    w[4] = s[0]; w[3] = s[1]; w[2] = s[2]; w[1] = s[3];
    return w;
  endfunction

  task automatic compare(input string tag);
    checks += 3;
    if (fsr !== place(m_st)) begin
      fails++; $display("FAIL %s fsr actual %h expected %h", tag, fsr, place(m_st));
    end
    if (esr_cause !== m_esr) begin
      fails++; $display("FAIL %s esr_cause actual %0d expected %0d", tag, esr_cause, m_esr);
    end
    if (exc_req !== m_req) begin
      fails++; $display("FAIL %s exc_req actual %0b expected %0b", tag, exc_req, m_req);
    end
  endtask

  task automatic step(input bit v, input bit cmp, input logic [3:0] f, input bit cfg,
                      input bit ee, input bit we, input logic [3:0] m, input logic [3:0] d,
                      input string tag);
    logic [3:0] e;
    bit q;
    @(negedge clk);
    compare(tag);
    op_valid = v; op_is_cmp = cmp; op_flags = f; cfg_trap_en = cfg; core_exc_en = ee;
    sw_we = we; sw_mask = m; sw_data = d;
    e = !v ? 4'b0 : (cmp ? {3'b000, f[0]} : f);
    q = (e != 0) && cfg && ee;
    m_req = m_pend;
    m_pend = q;
    if (q) m_esr = 5'd6;
    if (we) m_st = (m_st & ~m) | (d & m);
    m_st = m_st | e;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 4'h0, 0, 0, 0, 4'h0, 4'h0, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    idle(2, "R1 reset state");
    // single flags and their positions
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 4'h0, 0, 0, 1, 4'hF, 4'h0, "R8 clear");
      step(1, 0, 4'(1 << i), 0, 0, 0, 4'h0, 4'h0, "R2 single flag");
      idle(1, "R2 position");
    end
    step(1, 0, 4'h0, 0, 0, 0, 4'h0, 4'h0, "R3 no-flag op");
    step(1, 0, 4'h2, 0, 0, 0, 4'h0, 4'h0, "R3 accumulate");
    idle(2, "R3 hold");
    step(0, 0, 4'h0, 0, 0, 1, 4'hF, 4'h0, "R8 clear all");
    step(1, 1, 4'hE, 1, 1, 0, 4'h0, 4'h0, "R4 compare masked");
    idle(3, "R4 no trap");
    step(1, 1, 4'hF, 1, 1, 0, 4'h0, 4'h0, "R4 compare invalid");
    idle(3, "R4 trap");
    step(0, 0, 4'h0, 0, 0, 1, 4'hF, 4'h0, "R8 clear all");
    step(0, 0, 4'hF, 1, 1, 0, 4'h0, 4'h0, "R5 not valid");
    step(0, 1, 4'h5, 1, 1, 0, 4'h0, 4'h0, "R5 not valid");
    idle(3, "R5 ignored");
    step(1, 0, 4'h4, 0, 1, 0, 4'h0, 4'h0, "R6 cfg off");
    step(1, 0, 4'h4, 1, 0, 0, 4'h0, 4'h0, "R6 ee off");
    step(1, 0, 4'h0, 1, 1, 0, 4'h0, 4'h0, "R6 no flag");
    idle(3, "R6 no request");
    step(1, 0, 4'h8, 1, 1, 0, 4'h0, 4'h0, "R7 single trap");
    idle(3, "R7 pulse");
    step(1, 0, 4'h1, 1, 1, 0, 4'h0, 4'h0, "R7 back to back");
    step(1, 0, 4'h2, 1, 1, 0, 4'h0, 4'h0, "R7 back to back");
    step(1, 0, 4'h4, 1, 1, 0, 4'h0, 4'h0, "R7 back to back");
    idle(3, "R7 pulses");
    step(0, 0, 4'h0, 0, 0, 1, 4'hF, 4'hF, "R8 set all");
    step(1, 0, 4'h1, 0, 0, 1, 4'h3, 4'h0, "R8 same-bit collision");
    step(1, 0, 4'h8, 0, 0, 1, 4'h4, 4'h0, "R8 other-bit collision");
    idle(2, "R8 result");
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rf, rm, rd;
      int r;
      rf = 4'($urandom); rm = 4'($urandom); rd = 4'($urandom);
      r = $urandom_range(0, 99);
      step(r < 60, r % 3 == 0, (r % 4 == 0) ? 4'h0 : rf, r % 5 != 0, r % 7 != 0,
           r > 80, rm, rd, "R8 random mix");
    end
    idle(3, "R7 drain");
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule